// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block is the digital supervisor of a synchronous buck controller. When the enable input and the supply-ready flag are both high, it ramps a reference code from zero to full scale at a fixed step rate. It holds a coded power-good output in its weak pull-down state until a programmable delay has passed. It gates the PWM modulator and latches the first protection fault that occurs. The analog comparators for feedback level, supply level and die temperature live outside the block and reach it as digital flags. A fault pulse from the current-sense circuit arrives the same way.

The power-good code tells a pull-down driver which strength to use. This lets a board-level probe tell the cause of a shutdown from the pull-down resistance alone. After an overvoltage fault the block keeps control of the low-side switch. It runs it as a hysteretic crowbar, switching it on at the high feedback threshold and off at the low one, until the latch is cleared. Over-temperature pauses switching only. It latches nothing and leaves power-good as it was.

Top module: `ss_fault_sup`

## Requirements
- R1: While `en` or `por_ok` is low, `ref_code` is 0, `pwm_en` is 0, `lg_force` is 0 and `pg_code` is 0 (open).
- R2: Count n as the rising clock edges since `en` and `por_ok` both became high. `ref_code` then equals min(2^CODE_W-1, floor(n/STEP_CYC)). STEP_CYC is the full-scale ramp time in cycles divided by 2^CODE_W-1, and it is never less than 1.
- R3: Call the cycles from enable to power-good PG_CYC; this delay is its own parameter. With no fault, `pg_code` is 1 (weak) while n < PG_CYC and 0 (open) from n = PG_CYC on.
- R4: `pwm_en` is high exactly when enabled, no fault is latched and `ot_flag` is low. Raising `ot_flag` drops `pwm_en` in the same cycle but latches nothing and leaves `pg_code` unchanged. `pwm_en` returns when the flag clears.
- R5: `uv_flag` is ignored while n < PG_CYC.
- R6: An edge seen with `oc_flt` high latches code 3. One with `ov_rise` high latches code 2. One with `uv_flag` high after the delay latches code 1. The latched code drives `pg_code` from the next cycle, holds `pwm_en` low, and stays after the flag returns low.
- R7: If several fault inputs are high on the same edge, the priority is `oc_flt`, then `ov_rise`, then `uv_flag`. Once a code is latched, later faults do not change it.
- R8: While code 2 is latched, `lg_force` goes to 1 on each edge with `ov_rise` high and to 0 on each edge with `ov_clear` high. It keeps its value otherwise, and the cycling repeats until the latch is cleared. On an edge that latches code 3, `lg_force` is not set.
- R9: Taking `en` or `por_ok` low clears the latched fault and the crowbar. The next enable restarts the ramp and the delay from zero.
- R10: Taking `en` low drops `pwm_en` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter on/off request |
| por_ok | input | 1 | Supply above rising POR threshold (low once below falling threshold) |
| ov_rise | input | 1 | Feedback above the overvoltage rising threshold |
| ov_clear | input | 1 | Feedback below the overvoltage falling threshold |
| uv_flag | input | 1 | Feedback below the undervoltage threshold |
| ot_flag | input | 1 | Die over-temperature, hysteresis applied externally |
| oc_flt | input | 1 | Overcurrent or short-circuit fault pulse |
| ref_code | output | CODE_W | Soft-start reference code |
| pwm_en | output | 1 | Modulator enable |
| lg_force | output | 1 | Force low-side switch on (crowbar) |
| pg_code | output | 2 | Power-good pull-down: 0 open, 1 weak, 2 medium, 3 strong |

## Verification
The bench builds the block with a 3-bit reference code and a 1 MHz nominal clock. With a 14 µs ramp and a 30 µs delay, this gives two cycles per code step and a 30-cycle power-good delay. With these values every ramp step, the saturation point and the delay boundary are each checked cycle by cycle. There is also room to restart the block for every one of the seven combinations of simultaneous fault inputs, comparing each against a priority computed in the bench. The short delay also makes the window in which the undervoltage flag must be ignored long enough to test. It leaves time to repeat several crowbar on/off cycles and to check a clear through each of the two release inputs.

// File: rtl/ss_fault_sup.sv
module ss_fault_sup #(
  parameter int CODE_W   = 10,
  parameter int CLK_KHZ  = 100000,
  parameter int RAMP_US  = 1500,
  parameter int PGDLY_US = 2750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              por_ok,
  input  logic              ov_rise,
  input  logic              ov_clear,
  input  logic              uv_flag,
  input  logic              ot_flag,
  input  logic              oc_flt,
  output logic [CODE_W-1:0] ref_code,
  output logic              pwm_en,
  output logic              lg_force,
  output logic [1:0]        pg_code
);
  localparam int FULL     = (1 << CODE_W) - 1;
  localparam int RAMP_CYC = CLK_KHZ * RAMP_US / 1000;
  localparam int STEP_CYC = (RAMP_CYC / FULL > 0) ? RAMP_CYC / FULL : 1;
  localparam int PG_RAW   = CLK_KHZ * PGDLY_US / 1000;
  localparam int PG_CYC   = (PG_RAW > 0) ? PG_RAW : 1;
  localparam int DIV_W    = $clog2(STEP_CYC + 1);
  localparam int PG_W     = $clog2(PG_CYC + 1);

  typedef enum logic [1:0] {PG_OPEN = 2'd0, PG_WEAK = 2'd1, PG_MED = 2'd2, PG_STRONG = 2'd3} pg_t;

  logic [DIV_W-1:0]  div_q;
  logic [CODE_W-1:0] ramp_q;
  logic [PG_W-1:0]   tmr_q;
  pg_t               flt_q, flt_new;
  logic              crow_q;

  wire run     = en & por_ok;
  wire ss_done = (tmr_q == PG_W'(PG_CYC));
  wire crow_set = ov_rise & ((flt_q == PG_MED) | ((flt_q == PG_OPEN) & ~oc_flt));
  wire crow_clr = ov_clear & (flt_q == PG_MED);

  always_comb begin
    if (oc_flt)                  flt_new = PG_STRONG;
    else if (ov_rise)            flt_new = PG_MED;
    else if (uv_flag && ss_done) flt_new = PG_WEAK;
    else                         flt_new = PG_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ramp_q <= '0;
      tmr_q  <= '0;
      flt_q  <= PG_OPEN;
      crow_q <= 1'b0;
    end else if (!run) begin
      div_q  <= '0;
      ramp_q <= '0;
      tmr_q  <= '0;
      flt_q  <= PG_OPEN;
      crow_q <= 1'b0;
    end else begin
      if (div_q == DIV_W'(STEP_CYC - 1)) begin
        div_q <= '0;
        if (ramp_q != CODE_W'(FULL)) ramp_q <= ramp_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
      if (!ss_done) tmr_q <= tmr_q + 1'b1;
      if (flt_q == PG_OPEN) flt_q <= flt_new;
      if (crow_set)      crow_q <= 1'b1;
      else if (crow_clr) crow_q <= 1'b0;
    end
  end

  assign ref_code = run ? ramp_q : '0;
  assign pwm_en   = run & (flt_q == PG_OPEN) & ~ot_flag;
  assign lg_force = run & crow_q;
  assign pg_code  = !run                ? PG_OPEN :
                    (flt_q != PG_OPEN)  ? flt_q   :
                    !ss_done            ? PG_WEAK : PG_OPEN;
endmodule

module ss_fault_sup_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              por_ok,
  input logic              ot_flag,
  input logic [CODE_W-1:0] ref_code,
  input logic              pwm_en,
  input logic              lg_force,
  input logic [1:0]        pg_code
);
  wire on_now = en && por_ok;

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on_now |-> (!pwm_en && !lg_force && pg_code == 2'd0 && ref_code == '0));

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_now |=> (!(en && por_ok) || ref_code == $past(ref_code) || ref_code == $past(ref_code) + 1'b1));

  // R4
  pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> (!ot_flag && en && pg_code != 2'd3 && pg_code != 2'd2));

  // R7
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_now && pg_code == 2'd3) |=> (!(en && por_ok) || pg_code == 2'd3));

  // R8
  crowbar_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lg_force |-> pg_code == 2'd2);
endmodule

bind ss_fault_sup ss_fault_sup_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .por_ok(por_ok), .ot_flag(ot_flag),
  .ref_code(ref_code), .pwm_en(pwm_en), .lg_force(lg_force), .pg_code(pg_code)
);

// File: tb/sim_ss_fault_sup.sv
module sim_ss_fault_sup;
  localparam int CW = 3;
  localparam int FULLV = 7;
  localparam int STEP = 2;
  localparam int PGC = 30;

  logic clk = 0, rst_n = 0;
  logic en = 0, por_ok = 0, ov_rise = 0, ov_clear = 0, uv_flag = 0, ot_flag = 0, oc_flt = 0;
  logic [CW-1:0] ref_code;
  logic pwm_en, lg_force;
  logic [1:0] pg_code;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ss_fault_sup #(.CODE_W(CW), .CLK_KHZ(1000), .RAMP_US(14), .PGDLY_US(30)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .por_ok(por_ok), .ov_rise(ov_rise),
    .ov_clear(ov_clear), .uv_flag(uv_flag), .ot_flag(ot_flag), .oc_flt(oc_flt),
    .ref_code(ref_code), .pwm_en(pwm_en), .lg_force(lg_force), .pg_code(pg_code));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic restart();
    en = 0; por_ok = 1; oc_flt = 0; ov_rise = 0; ov_clear = 0; uv_flag = 0; ot_flag = 0;
    tick();
    chk("R9 cleared pg", pg_code, 0);
    chk("R9 cleared lg", lg_force, 0);
    en = 1;
    repeat (PGC + 2) tick();
  endtask

  initial begin
    #3000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    tick();
    // R1 off state
    chk("R1 pwm", pwm_en, 0); chk("R1 pg", pg_code, 0); chk("R1 ref", ref_code, 0); chk("R1 lg", lg_force, 0);
    en = 1; tick();
    chk("R1 por low pwm", pwm_en, 0); chk("R1 por low pg", pg_code, 0);
    en = 0; por_ok = 1; tick();
    chk("R1 en low pwm", pwm_en, 0);
    en = 1; #1;
    chk("R2 ref n=0", ref_code, 0); chk("R3 pg n=0", pg_code, 1); chk("R4 pwm n=0", pwm_en, 1);
    for (int k = 1; k <= 40; k++) begin
      tick();
      chk("R2 ramp", ref_code, (k / STEP > FULLV) ? FULLV : k / STEP);
      chk("R3 pg delay", pg_code, (k >= PGC) ? 0 : 1);
      if (k == 5) uv_flag = 1;      // R5 window
      if (k == 20) uv_flag = 0;
    end
    chk("R5 uv ignored pwm", pwm_en, 1);
    // R4 over-temperature
    ot_flag = 1; #1;
    chk("R4 ot pwm", pwm_en, 0); chk("R4 ot pg", pg_code, 0);
    tick(); tick();
    chk("R4 ot no latch pg", pg_code, 0); chk("R4 ot ref", ref_code, FULLV);
    ot_flag = 0; #1;
    chk("R4 ot resume", pwm_en, 1);
    // R10 immediate stop
    en = 0; #1;
    chk("R10 pwm drop", pwm_en, 0);
    tick(); en = 1;
    repeat (PGC + 2) tick();
    // R6 UV after delay
    uv_flag = 1; tick(); uv_flag = 0; tick();
    chk("R6 uv code", pg_code, 1); chk("R6 uv pwm", pwm_en, 0);
    // R6 OC then R7 later fault ignored
    restart();
    oc_flt = 1; tick(); oc_flt = 0;
    chk("R6 oc code", pg_code, 3); chk("R6 oc pwm", pwm_en, 0);
    ov_rise = 1; tick(); ov_rise = 0; tick();
    chk("R7 hold oc", pg_code, 3); chk("R8 no crowbar on oc", lg_force, 0);
    // R8 crowbar cycling
    restart();
    ov_rise = 1; tick();
    chk("R6 ov code", pg_code, 2); chk("R8 lg on", lg_force, 1); chk("R6 ov pwm", pwm_en, 0);
    for (int c = 0; c < 3; c++) begin
      ov_rise = 0; tick(); chk("R8 lg hold high", lg_force, 1);
      ov_clear = 1; tick(); ov_clear = 0; chk("R8 lg off", lg_force, 0);
      tick(); chk("R8 lg hold low", lg_force, 0);
      ov_rise = 1; tick(); chk("R8 lg on again", lg_force, 1);
    end
    ov_rise = 0; uv_flag = 1; tick(); uv_flag = 0;
    chk("R7 ov held", pg_code, 2);
    // R9 clear via por
    por_ok = 0; tick();
    chk("R9 por clear pg", pg_code, 0); chk("R9 por clear lg", lg_force, 0); chk("R9 por clear ref", ref_code, 0);
    por_ok = 1; tick(); tick();
    chk("R9 restart ramp", ref_code, 1); chk("R9 restart pg", pg_code, 1); chk("R9 restart pwm", pwm_en, 1);
    // R7 priority sweep
    for (int m = 1; m < 8; m++) begin
      restart();
      oc_flt = m[2]; ov_rise = m[1]; uv_flag = m[0];
      tick();
      oc_flt = 0; ov_rise = 0; uv_flag = 0;
      tick();
      chk("R7 priority", pg_code, m[2] ? 3 : (m[1] ? 2 : 1));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule